// File: doc/BRIEF.md
# Victim Line Writeback Controller

This block retires one cache line that the replacement logic has picked as a victim. When a replacement is accepted, the line's address, data and dirty bit are captured in a single transaction buffer. The block then issues a victim request to the directory. An owned or modified line produces a dirty request; an exclusive or shared line produces a clean one. In the same cycle it pulses an invalidate for the array entry. It then waits for the memory writeback acknowledgement before it frees the buffer.

While it waits, the block resolves races on the same address:
- An invalidating probe cancels the writeback, and the block then waits for the acknowledgement with the line held off.
- An upper-level victim request that reaches a dirty eviction is acknowledged. The data that follows is dropped with a not-valid unblock.
- If the memory acknowledgement arrives first, the later data or stale notice completes the eviction.
- Read requests are forwarded as misses.
- Victim requests that cannot be taken are sent back for retry.

Top module: `evict_wb_ctrl`

## Requirements
- R1: After reset the buffer is free: `repl_ready` is 1 and every output pulse is 0.
- R2: A replacement accepted with `repl_kind` 3 (modified) or 2 (owned) gives, one cycle later, a one-cycle pulse on `vic_valid` with `vic_dirty_req`=1 and on `inval_valid`. In that same cycle `vic_addr`, `vic_data` and `vic_data_dirty` equal the captured address, data and dirty bit.
- R3: A replacement accepted with `repl_kind` 1 (exclusive) or 0 (shared) gives the same pulses one cycle later, with `vic_dirty_req`=0.
- R4: `repl_ready` is 0 while the buffer is occupied. A replacement offered then produces no victim request and does not change the captured address.
- R5: A matching acknowledgement while the block waits after either kind of eviction frees the buffer, so `repl_ready` is 1 one cycle later.
- R6: A matching invalidating probe (`probe_inv`=1) while the block waits gives a `cancel_valid` pulse one cycle later. The buffer stays occupied until the acknowledgement arrives. A probe with `probe_inv`=0 has no effect.
- R7: A matching victim request (`req_victim`=1) gives `req_retry` one cycle later in every busy state except the dirty-eviction wait. That includes the cancelled state.
- R8: In the dirty-eviction wait, a matching victim request gives `req_wback_ack`. The following matching data (`fill_stale`=0) gives `unblock_valid` and returns the block to the dirty-eviction wait.
- R9: An acknowledgement that arrives after a victim request was acknowledged keeps the buffer occupied. The next matching data or stale notice then gives `unblock_valid` and frees the buffer.
- R10: A matching read request (`req_victim`=0) while busy gives `req_fwd_miss` one cycle later.
- R11: Acknowledgements, probes, data and requests whose address differs from the captured address have no effect.
- R12: In one cycle, a matching acknowledgement takes precedence over a probe, which takes precedence over data, which takes precedence over a request. A matching request that arrives alongside any of the others gets `req_retry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| repl_valid | input | 1 | Replacement offered |
| repl_ready | output | 1 | Buffer free, replacement accepted |
| repl_addr | input | AW | Victim line address |
| repl_kind | input | 2 | Line state: 0 shared, 1 exclusive, 2 owned, 3 modified |
| repl_data | input | DW | Victim line data |
| repl_dirty | input | 1 | Victim line dirty bit |
| ack_valid | input | 1 | Memory writeback acknowledgement |
| ack_addr | input | AW | Acknowledgement address |
| probe_valid | input | 1 | Probe event |
| probe_addr | input | AW | Probe address |
| probe_inv | input | 1 | Probe is invalidating |
| fill_valid | input | 1 | Upper-level data or stale notice |
| fill_addr | input | AW | Data/stale address |
| fill_stale | input | 1 | 1 for stale notice, 0 for data |
| req_valid | input | 1 | Upper-level request |
| req_addr | input | AW | Request address |
| req_victim | input | 1 | 1 victim request, 0 read |
| vic_valid | output | 1 | Victim request pulse |
| vic_dirty_req | output | 1 | Victim request is dirty |
| vic_addr | output | AW | Captured address |
| vic_data | output | DW | Captured data |
| vic_data_dirty | output | 1 | Captured dirty bit |
| inval_valid | output | 1 | Array invalidate pulse |
| cancel_valid | output | 1 | Writeback cancel pulse |
| req_wback_ack | output | 1 | Victim request acknowledged |
| req_retry | output | 1 | Request must be retried |
| req_fwd_miss | output | 1 | Read forwarded as miss |
| unblock_valid | output | 1 | Not-valid unblock pulse |

## Verification
Every pulse output is registered, so each one appears in the cycle right after the clock edge that took its event. `repl_ready` depends only on the state register, so it shows the new buffer state right after that same edge. The bench drives each event on a falling edge, lets one rising edge pass, and samples at the next falling edge. It then samples once more to confirm the pulses last a single cycle. State that is not visible directly is read through later responses: `repl_ready`, a retry versus an acknowledgement, and an unblock versus no response.

// File: rtl/evwb_pkg.sv
package evwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_DIRTY_WT  = 3'd1,
    ST_CLEAN_WT  = 3'd2,
    ST_CANCELLED = 3'd3,
    ST_DROP_DATA = 3'd4,
    ST_DROP_LAST = 3'd5
  } evwb_state_e;

  typedef struct packed {
    logic vic_send;
    logic vic_dirty;
    logic load;
    logic cancel;
    logic wback_ack;
    logic retry;
    logic fwd_miss;
    logic unblock;
  } evwb_act_t;
endpackage

// File: rtl/evwb_fsm.sv
module evwb_fsm
  import evwb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        repl_go,
  input  logic        repl_dirty_kind,
  input  logic        ev_ack,
  input  logic        ev_probe,
  input  logic        ev_fill,
  input  logic        ev_fill_stale,
  input  logic        ev_req,
  input  logic        ev_req_victim,
  output evwb_state_e state_q,
  output evwb_act_t   act
);
  evwb_state_e state_d;
  logic        higher_evt;

  always_comb begin
    state_d    = state_q;
    act        = '0;
    higher_evt = ev_ack | ev_probe | ev_fill;
    if (state_q == ST_IDLE) begin
      if (repl_go) begin
        act.vic_send  = 1'b1;
        act.vic_dirty = repl_dirty_kind;
        act.load      = 1'b1;
        state_d       = repl_dirty_kind ? ST_DIRTY_WT : ST_CLEAN_WT;
      end
    end else begin
      if (ev_ack) begin
        case (state_q)
          ST_DIRTY_WT, ST_CLEAN_WT, ST_CANCELLED: state_d = ST_IDLE;
          ST_DROP_DATA:                           state_d = ST_DROP_LAST;
          default:                                state_d = state_q;
        endcase
      end else if (ev_probe) begin
        if (state_q == ST_DIRTY_WT || state_q == ST_CLEAN_WT) begin
          act.cancel = 1'b1;
          state_d    = ST_CANCELLED;
        end
      end else if (ev_fill) begin
        if (state_q == ST_DROP_DATA && !ev_fill_stale) begin
          act.unblock = 1'b1;
          state_d     = ST_DIRTY_WT;
        end else if (state_q == ST_DROP_LAST) begin
          act.unblock = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      if (ev_req) begin
        if (higher_evt) begin
          act.retry = 1'b1;
        end else if (!ev_req_victim) begin
          act.fwd_miss = 1'b1;
        end else if (state_q == ST_DIRTY_WT) begin
          act.wback_ack = 1'b1;
          state_d       = ST_DROP_DATA;
        end else begin
          act.retry = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_ack_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && (state_q == ST_DIRTY_WT || state_q == ST_CLEAN_WT)) |=> state_q == ST_IDLE);
  assert_probe_cancels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_probe && !ev_ack && (state_q == ST_DIRTY_WT || state_q == ST_CLEAN_WT))
      |=> state_q == ST_CANCELLED);
  assert_late_ack_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && state_q == ST_DROP_DATA) |=> state_q == ST_DROP_LAST);
endmodule

// File: rtl/evwb_tbe.sv
module evwb_tbe #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          dirty_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          dirty_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      dirty_q <= 1'b0;
    end else if (load_en) begin
      addr_q  <= addr_in;
      data_q  <= data_in;
      dirty_q <= dirty_in;
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(addr_q) && $stable(data_q));
endmodule

// File: rtl/evwb_outreg.sv
module evwb_outreg
  import evwb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  evwb_act_t act_in,
  output evwb_act_t act_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_in;
  end

  assert_one_reply_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_q.retry, act_q.fwd_miss, act_q.wback_ack}));
endmodule

// File: rtl/evict_wb_ctrl.sv
module evict_wb_ctrl
  import evwb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          repl_valid,
  output logic          repl_ready,
  input  logic [AW-1:0] repl_addr,
  input  logic [1:0]    repl_kind,
  input  logic [DW-1:0] repl_data,
  input  logic          repl_dirty,
  input  logic          ack_valid,
  input  logic [AW-1:0] ack_addr,
  input  logic          probe_valid,
  input  logic [AW-1:0] probe_addr,
  input  logic          probe_inv,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_addr,
  input  logic          fill_stale,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_victim,
  output logic          vic_valid,
  output logic          vic_dirty_req,
  output logic [AW-1:0] vic_addr,
  output logic [DW-1:0] vic_data,
  output logic          vic_data_dirty,
  output logic          inval_valid,
  output logic          cancel_valid,
  output logic          req_wback_ack,
  output logic          req_retry,
  output logic          req_fwd_miss,
  output logic          unblock_valid
);
  evwb_state_e   state_q;
  evwb_act_t     act, act_q;
  logic          busy, repl_go;
  logic          ev_ack, ev_probe, ev_fill, ev_req;
  logic [AW-1:0] tbe_addr;

  assign busy       = (state_q != ST_IDLE);
  assign repl_ready = !busy;
  assign repl_go    = repl_valid && !busy;
  assign ev_ack     = busy && ack_valid   && (ack_addr   == tbe_addr);
  assign ev_probe   = busy && probe_valid && probe_inv && (probe_addr == tbe_addr);
  assign ev_fill    = busy && fill_valid  && (fill_addr  == tbe_addr);
  assign ev_req     = busy && req_valid   && (req_addr   == tbe_addr);

  evwb_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .repl_go        (repl_go),
    .repl_dirty_kind(repl_kind[1]),
    .ev_ack         (ev_ack),
    .ev_probe       (ev_probe),
    .ev_fill        (ev_fill),
    .ev_fill_stale  (fill_stale),
    .ev_req         (ev_req),
    .ev_req_victim  (req_victim),
    .state_q        (state_q),
    .act            (act)
  );

  evwb_tbe #(.AW(AW), .DW(DW)) u_tbe (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (act.load),
    .addr_in (repl_addr),
    .data_in (repl_data),
    .dirty_in(repl_dirty),
    .addr_q  (tbe_addr),
    .data_q  (vic_data),
    .dirty_q (vic_data_dirty)
  );

  evwb_outreg u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .act_in(act),
    .act_q (act_q)
  );

  assign vic_addr      = tbe_addr;
  assign vic_valid     = act_q.vic_send;
  assign vic_dirty_req = act_q.vic_dirty;
  assign inval_valid   = act_q.load;
  assign cancel_valid  = act_q.cancel;
  assign req_wback_ack = act_q.wback_ack;
  assign req_retry     = act_q.retry;
  assign req_fwd_miss  = act_q.fwd_miss;
  assign unblock_valid = act_q.unblock;

  assert_refused_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_valid && !repl_ready) |=> !vic_valid);
  assert_dirty_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_valid && repl_ready && repl_kind[1]) |=> vic_valid && vic_dirty_req && inval_valid);
  assert_clean_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_valid && repl_ready && !repl_kind[1]) |=> vic_valid && !vic_dirty_req && inval_valid);
endmodule

// File: tb/evict_wb_ctrl_tb_top.sv
module evict_wb_ctrl_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic repl_valid, repl_ready, repl_dirty;
  logic [AW-1:0] repl_addr, ack_addr, probe_addr, fill_addr, req_addr, vic_addr;
  logic [1:0] repl_kind;
  logic [DW-1:0] repl_data, vic_data;
  logic ack_valid, probe_valid, probe_inv, fill_valid, fill_stale, req_valid, req_victim;
  logic vic_valid, vic_dirty_req, vic_data_dirty, inval_valid, cancel_valid;
  logic req_wback_ack, req_retry, req_fwd_miss, unblock_valid;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evict_wb_ctrl #(.AW(AW), .DW(DW)) dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    repl_valid = 0; ack_valid = 0; probe_valid = 0; fill_valid = 0; req_valid = 0;
  endtask

  // inputs set at a falling edge; one rising edge passes; sample at next falling edge
  task automatic tick();
    @(negedge clk);
    clear_in();
  endtask

  task automatic replace(input logic [AW-1:0] a, input logic [1:0] k, input logic [DW-1:0] d, input logic dt);
    repl_valid = 1; repl_addr = a; repl_kind = k; repl_data = d; repl_dirty = dt;
    tick();
  endtask
  task automatic ack(input logic [AW-1:0] a);
    ack_valid = 1; ack_addr = a; tick();
  endtask
  task automatic probe(input logic [AW-1:0] a, input logic inv);
    probe_valid = 1; probe_addr = a; probe_inv = inv; tick();
  endtask
  task automatic fill(input logic [AW-1:0] a, input logic st);
    fill_valid = 1; fill_addr = a; fill_stale = st; tick();
  endtask
  task automatic request(input logic [AW-1:0] a, input logic vic);
    req_valid = 1; req_addr = a; req_victim = vic; tick();
  endtask

  task automatic t_reset();
    chk("R1 ready", repl_ready, 1);
    chk("R1 pulses", {vic_valid, inval_valid, cancel_valid, req_wback_ack, req_retry, req_fwd_miss, unblock_valid}, 0);
  endtask

  task automatic t_dirty_evict();
    replace(16'h1A40, 2'd3, 32'hDEAD_BEEF, 1);
    chk("R2 vic_valid", vic_valid, 1);
    chk("R2 dirty req", vic_dirty_req, 1);
    chk("R2 inval", inval_valid, 1);
    chk("R2 addr", vic_addr, 16'h1A40);
    chk("R2 data", vic_data, 32'hDEAD_BEEF);
    chk("R2 data dirty", vic_data_dirty, 1);
    chk("R4 busy", repl_ready, 0);
    replace(16'h2222, 2'd0, 32'h1111_1111, 0);
    chk("R4 no request", vic_valid, 0);
    chk("R4 addr kept", vic_addr, 16'h1A40);
    ack(16'h1A41);
    chk("R11 wrong ack", repl_ready, 0);
    request(16'h1A44, 1);
    chk("R11 wrong req", {req_retry, req_wback_ack, req_fwd_miss}, 0);
    ack(16'h1A40);
    chk("R5 freed dirty", repl_ready, 1);
    chk("R5 no pulse", vic_valid, 0);
  endtask

  task automatic t_clean_evict();
    replace(16'h0300, 2'd0, 32'h0000_5555, 0);
    chk("R3 vic_valid", vic_valid, 1);
    chk("R3 clean req", vic_dirty_req, 0);
    chk("R3 inval", inval_valid, 1);
    request(16'h0300, 0);
    chk("R10 fwd miss", req_fwd_miss, 1);
    request(16'h0300, 1);
    chk("R7 retry clean wait", req_retry, 1);
    chk("R7 no ack", req_wback_ack, 0);
    ack(16'h0300);
    chk("R5 freed clean", repl_ready, 1);
  endtask

  task automatic t_owned_cancel();
    replace(16'h0440, 2'd2, 32'hAAAA_0000, 1);
    chk("R2 owned dirty req", vic_dirty_req, 1);
    probe(16'h0440, 0);
    chk("R6 non-inv probe", cancel_valid, 0);
    probe(16'h0999, 1);
    chk("R11 wrong probe", cancel_valid, 0);
    request(16'h0440, 1);
    chk("R6 still dirty wait", req_wback_ack, 1);
    fill(16'h0440, 0);
    chk("R8 drop data unblock", unblock_valid, 1);
    probe(16'h0440, 1);
    chk("R6 cancel", cancel_valid, 1);
    request(16'h0440, 1);
    chk("R7 retry cancelled", req_retry, 1);
    chk("R6 held", repl_ready, 0);
    ack(16'h0440);
    chk("R6 freed", repl_ready, 1);
  endtask

  task automatic t_drop_loop();
    replace(16'h0550, 2'd3, 32'h1234_5678, 1);
    request(16'h0550, 1);
    chk("R8 wback ack", req_wback_ack, 1);
    fill(16'h0550, 1);
    chk("R8 stale ignored", unblock_valid, 0);
    fill(16'h0550, 0);
    chk("R8 unblock", unblock_valid, 1);
    chk("R8 still busy", repl_ready, 0);
    request(16'h0550, 1);
    chk("R8 back to dirty wait", req_wback_ack, 1);
    fill(16'h0550, 0);
    chk("R8 unblock again", unblock_valid, 1);
    ack(16'h0550);
    chk("R8 freed", repl_ready, 1);
  endtask

  task automatic t_late_ack(input logic stale);
    replace(16'h0660, 2'd3, 32'hCAFE_F00D, 1);
    request(16'h0660, 1);
    ack(16'h0660);
    chk("R9 held after ack", repl_ready, 0);
    request(16'h0660, 1);
    chk("R9 retry after ack", req_retry, 1);
    fill(16'h0660, stale);
    chk("R9 unblock", unblock_valid, 1);
    chk("R9 freed", repl_ready, 1);
  endtask

  task automatic t_priority();
    replace(16'h0770, 2'd3, 32'h0F0F_0F0F, 0);
    ack_valid = 1; ack_addr = 16'h0770; req_valid = 1; req_addr = 16'h0770; req_victim = 1;
    tick();
    chk("R12 retry on collision", req_retry, 1);
    chk("R12 no ack reply", req_wback_ack, 0);
    chk("R12 ack won", repl_ready, 1);
    replace(16'h0880, 2'd1, 32'h0, 0);
    ack_valid = 1; ack_addr = 16'h0880; probe_valid = 1; probe_addr = 16'h0880; probe_inv = 1;
    tick();
    chk("R12 ack over probe", cancel_valid, 0);
    chk("R12 freed", repl_ready, 1);
  endtask

  initial begin
    clear_in();
    repl_addr = 0; repl_kind = 0; repl_data = 0; repl_dirty = 0;
    ack_addr = 0; probe_addr = 0; probe_inv = 0; fill_addr = 0; fill_stale = 0;
    req_addr = 0; req_victim = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dirty_evict();
    t_clean_evict();
    t_owned_cancel();
    t_drop_loop();
    t_late_ack(1);
    t_late_ack(0);
    t_priority();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule